// File: doc/BRIEF.md
# Pulse-Pause Frame Decoder

This block is the receive half of a tag front end that listens to a reader. The reader sends by switching its carrier off for short gaps. The time the carrier stays on between two gaps carries one bit: a long on-period is a '1' and a short one is a '0'. The block synchronises the envelope level and counts ticks from a tick-enable input. At every level change it takes the number of ticks since the previous change and restarts the count. Intervals that fall inside the '1' window or the '0' window become bits. Bits are packed into a frame register, LSB first.

A frame has no explicit length or end marker. Once the first bit of a frame has been decoded, the frame closes when the interval counter has run for the '1' length plus the tolerance without any level change. A frame that is long enough is then presented for one clock with its bit count. A shorter one is treated as noise and cleared silently. If the line stays quiet for a long time, the interval counter stops. It starts again at the next level change.

Top module: `ppm_frame_rx`

## Requirements
- R1: While reset is asserted and after release with a quiet line, `frm_valid` is 0, `frm_bits` is 0, `frm_data` is 0 and `tmr_run` is 0.
- R2: An interval strictly greater than ONE_TICKS-FUZZ_TICKS and strictly less than ONE_TICKS+FUZZ_TICKS (101..139 ticks with defaults) appends a 1 bit.
- R3: An interval strictly greater than ZERO_TICKS-FUZZ_TICKS and strictly less than ZERO_TICKS+FUZZ_TICKS (41..79 ticks with defaults) appends a 0 bit.
- R4: An interval outside both windows, including the exact boundary values 40, 80 and 100 and the short gap interval, appends nothing and does not close the frame.
- R5: The bit decoded k-th in a frame (k from 0) appears at `frm_data[k]`, and `frm_bits` equals the number of bits decoded.
- R6: Once a frame holds at least one bit, the interval counter reaching ONE_TICKS+FUZZ_TICKS ticks without a level change closes the frame. With full-rate ticks and the default two-stage synchroniser, `frm_valid` rises 142 clocks after the edge that sets the level, counted from the first clock edge that samples that level, and it lasts exactly one clock.
- R7: A frame closing with RUNT_BITS (4) bits or fewer produces no `frm_valid`, and its contents are cleared.
- R8: Bits beyond MAX_BITS (31) are ignored: `frm_bits` stops at 31 and `frm_data` keeps the first 31 bits.
- R9: In the clock after `frm_valid`, `frm_data` and `frm_bits` read 0.
- R10: With no level change, the interval counter stops after IDLE_MULT*ONE_TICKS (2400) ticks and `tmr_run` falls. It restarts at the next level change and `tmr_run` rises.
- R11: Intervals are measured in `tick_en` pulses rather than clocks, so cycles where `tick_en` is low do not advance the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Tick strobe that advances the interval counter |
| env_in | input | 1 | Raw envelope level (1 = carrier present), asynchronous |
| frm_valid | output | 1 | One-clock strobe: a complete frame is on `frm_data`/`frm_bits` |
| frm_data | output | MAX_BITS (31) | Frame bits, first decoded bit in bit 0 |
| frm_bits | output | 5 | Number of valid bits in `frm_data` |
| tmr_run | output | 1 | Interval counter is running (not idle-stopped) |

## Verification
The bench drives on-period lengths on both sides of each window edge: 101/139 and 41/79 must decode, while 100, 80 and 40 must vanish without ending the frame. A design with closed rather than open windows would insert bits, and one that ends the frame on a bad interval would report a short frame. It sends frames of exactly 4 and 5 bits to catch an off-by-one in runt rejection, and a 34-bit frame to show that overflow saturates at 31 rather than wrapping onto bit 0. It counts the clocks from the last edge to the strobe and to the idle stop, so a counter that starts at the wrong value or compares with the wrong limit shows up. It also runs a frame at half tick rate, which exposes a counter that ignores the tick enable.

// File: rtl/ppm_pkg.sv
package ppm_pkg;

  typedef enum logic [1:0] {
    SYM_NONE = 2'd0,
    SYM_ZERO = 2'd1,
    SYM_ONE  = 2'd2
  } sym_e;

endpackage

// File: rtl/ppm_sync.sv
module ppm_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out
);

  logic [STAGES-1:0] sh_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic src;
    if (g == 0) begin : g_first
      assign src = d_in;
    end else begin : g_rest
      assign src = sh_q[g-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q[g] <= RST_VAL;
      else        sh_q[g] <= src;
    end
  end

  assign q_out = sh_q[STAGES-1];

endmodule

// File: rtl/ppm_edge_timer.sv
module ppm_edge_timer #(
  parameter int   CNT_W      = 12,
  parameter int   IDLE_LIMIT = 2400,
  parameter logic RST_VAL    = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl_in,
  input  logic             tick_en,
  output logic             edge_stb,
  output logic [CNT_W-1:0] elapsed,
  output logic             run
);

  localparam logic [CNT_W-1:0] IDLE_CNT = CNT_W'(IDLE_LIMIT);
  localparam logic [CNT_W-1:0] IDLE_PRE = CNT_W'(IDLE_LIMIT - 1);

  logic             lvl_q;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             run_q, run_n;

  assign edge_stb = (lvl_in != lvl_q);

  // Next state: an edge restarts the count, counting its own tick as the first
  always_comb begin
    cnt_n = cnt_q;
    run_n = run_q;
    if (edge_stb) begin
      run_n = 1'b1;
      cnt_n = tick_en ? CNT_W'(1) : '0;
    end else if (run_q && tick_en) begin
      if (cnt_q >= IDLE_PRE) begin
        cnt_n = IDLE_CNT;
        run_n = 1'b0;
      end else begin
        cnt_n = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= RST_VAL;
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      lvl_q <= lvl_in;
      cnt_q <= cnt_n;
      run_q <= run_n;
    end
  end

  assign elapsed = cnt_q;
  assign run     = run_q;

  AST_IDLE_STOP_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> (cnt_q == IDLE_CNT)); // R10

  AST_EDGE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    edge_stb |=> run_q); // R10

  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!edge_stb && !tick_en) |=> $stable(cnt_q)); // R11

endmodule

// File: rtl/ppm_sym_class.sv
module ppm_sym_class
  import ppm_pkg::*;
#(
  parameter int CNT_W      = 12,
  parameter int ONE_TICKS  = 120,
  parameter int ZERO_TICKS = 60,
  parameter int FUZZ_TICKS = 20
) (
  input  logic [CNT_W-1:0] elapsed,
  output sym_e             sym
);

  localparam logic [CNT_W-1:0] ONE_LO  = CNT_W'(ONE_TICKS - FUZZ_TICKS);
  localparam logic [CNT_W-1:0] ONE_HI  = CNT_W'(ONE_TICKS + FUZZ_TICKS);
  localparam logic [CNT_W-1:0] ZERO_LO = CNT_W'(ZERO_TICKS - FUZZ_TICKS);
  localparam logic [CNT_W-1:0] ZERO_HI = CNT_W'(ZERO_TICKS + FUZZ_TICKS);

  logic in_one, in_zero;

  assign in_one  = (elapsed > ONE_LO)  && (elapsed < ONE_HI);
  assign in_zero = (elapsed > ZERO_LO) && (elapsed < ZERO_HI);

  always_comb begin
    if (in_one)       sym = SYM_ONE;
    else if (in_zero) sym = SYM_ZERO;
    else              sym = SYM_NONE;
  end

endmodule

// File: rtl/ppm_frame_asm.sv
module ppm_frame_asm
  import ppm_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int BITS_W    = 5,
  parameter int MAX_BITS  = 31,
  parameter int RUNT_BITS = 4,
  parameter int END_LIMIT = 140
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sym_stb,
  input  sym_e                sym,
  input  logic [CNT_W-1:0]    elapsed,
  output logic                frm_valid,
  output logic [MAX_BITS-1:0] frm_data,
  output logic [BITS_W-1:0]   frm_bits
);

  localparam logic [BITS_W-1:0] MAX_CNT  = BITS_W'(MAX_BITS);
  localparam logic [BITS_W-1:0] RUNT_CNT = BITS_W'(RUNT_BITS);
  localparam logic [CNT_W-1:0]  END_CNT  = CNT_W'(END_LIMIT);

  logic [MAX_BITS-1:0] data_q, data_n;
  logic [BITS_W-1:0]   bits_q, bits_n;
  logic                act_q, act_n;
  logic                vld_q, vld_n;
  logic                close_hit;
  logic                bit_hit;

  assign close_hit = act_q && (elapsed >= END_CNT);
  assign bit_hit   = sym_stb && (sym != SYM_NONE);

  always_comb begin
    data_n = data_q;
    bits_n = bits_q;
    act_n  = act_q;
    vld_n  = 1'b0;
    if (vld_q) begin
      data_n = '0;
      bits_n = '0;
    end
    if (close_hit) begin
      act_n = 1'b0;
      if (bits_q > RUNT_CNT) begin
        vld_n = 1'b1;
      end else begin
        data_n = '0;
        bits_n = '0;
      end
    end else if (bit_hit) begin
      act_n = 1'b1;
      if (bits_n < MAX_CNT) begin
        data_n[bits_n] = (sym == SYM_ONE);
        bits_n         = bits_n + BITS_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      bits_q <= '0;
      act_q  <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      data_q <= data_n;
      bits_q <= bits_n;
      act_q  <= act_n;
      vld_q  <= vld_n;
    end
  end

  assign frm_valid = vld_q;
  assign frm_data  = data_q;
  assign frm_bits  = bits_q;

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q); // R6

  AST_NO_RUNT_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> (bits_q > RUNT_CNT)); // R7

  AST_CLEAR_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> (bits_q == '0) && (data_q == '0)); // R9

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    bits_q <= MAX_CNT); // R8

  AST_IGNORED_NO_APPEND: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_stb && sym == SYM_NONE && !close_hit && !vld_q) |=> $stable(bits_q)); // R4

endmodule

// File: rtl/ppm_frame_rx.sv
module ppm_frame_rx
  import ppm_pkg::*;
#(
  parameter int ONE_TICKS   = 120,
  parameter int ZERO_TICKS  = 60,
  parameter int FUZZ_TICKS  = 20,
  parameter int IDLE_MULT   = 20,
  parameter int MAX_BITS    = 31,
  parameter int RUNT_BITS   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                tick_en,
  input  logic                                env_in,
  output logic                                frm_valid,
  output logic [MAX_BITS-1:0]                 frm_data,
  output logic [$clog2(MAX_BITS+1)-1:0]       frm_bits,
  output logic                                tmr_run
);

  localparam int IDLE_LIMIT = IDLE_MULT * ONE_TICKS;
  localparam int END_LIMIT  = ONE_TICKS + FUZZ_TICKS;
  localparam int CNT_W      = $clog2(IDLE_LIMIT + 1);
  localparam int BITS_W     = $clog2(MAX_BITS + 1);

  logic             lvl_s;
  logic             edge_stb;
  logic [CNT_W-1:0] elapsed;
  sym_e             sym;

  ppm_sync #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b1)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (env_in),
    .q_out (lvl_s)
  );

  ppm_edge_timer #(
    .CNT_W      (CNT_W),
    .IDLE_LIMIT (IDLE_LIMIT),
    .RST_VAL    (1'b1)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl_in   (lvl_s),
    .tick_en  (tick_en),
    .edge_stb (edge_stb),
    .elapsed  (elapsed),
    .run      (tmr_run)
  );

  ppm_sym_class #(
    .CNT_W      (CNT_W),
    .ONE_TICKS  (ONE_TICKS),
    .ZERO_TICKS (ZERO_TICKS),
    .FUZZ_TICKS (FUZZ_TICKS)
  ) u_class (
    .elapsed (elapsed),
    .sym     (sym)
  );

  ppm_frame_asm #(
    .CNT_W     (CNT_W),
    .BITS_W    (BITS_W),
    .MAX_BITS  (MAX_BITS),
    .RUNT_BITS (RUNT_BITS),
    .END_LIMIT (END_LIMIT)
  ) u_asm (
    .clk       (clk),
    .rst_n     (rst_n),
    .sym_stb   (edge_stb),
    .sym       (sym),
    .elapsed   (elapsed),
    .frm_valid (frm_valid),
    .frm_data  (frm_data),
    .frm_bits  (frm_bits)
  );

endmodule

// File: tb/ppm_frame_rx_bench.sv
module ppm_frame_rx_bench;

  localparam int CLK_PERIOD = 10;
  localparam int GAP        = 30;
  localparam int POLL       = 400;
  localparam int NV         = 6;

  localparam int          V_BITS [NV] = '{8, 5, 12, 4, 31, 34};
  localparam logic [31:0] V_PAT  [NV] = '{32'h0000_00A5, 32'h0000_001B, 32'h0000_09C3,
                                          32'h0000_000F, 32'h2D5A_5A5A, 32'h5555_5555};
  localparam int          V_ONE  [NV] = '{120, 101, 139, 120, 120, 120};
  localparam int          V_ZERO [NV] = '{60, 41, 79, 60, 60, 60};

  logic        clk;
  logic        rst_n;
  logic        tick_en;
  logic        env_in;
  logic        frm_valid;
  logic [30:0] frm_data;
  logic [4:0]  frm_bits;
  logic        tmr_run;

  int checks;
  int failures;
  bit half_rate;
  int lens [64];
  int nlens;
  int seen;
  int v_k;
  logic [30:0] cap_data;
  logic [4:0]  cap_bits;

  ppm_frame_rx u_ppm_frame_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_en   (tick_en),
    .env_in    (env_in),
    .frm_valid (frm_valid),
    .frm_data  (frm_data),
    .frm_bits  (frm_bits),
    .tmr_run   (tmr_run)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  initial begin
    tick_en = 1'b1;
    forever begin
      @(negedge clk);
      tick_en = half_rate ? ~tick_en : 1'b1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog run did not complete actual=0x0 expected=0x1");
    finish_run();
  end

  // Sends the on-periods in lens[0..nlens-1], then polls for the frame strobe
  task automatic send_frame();
    @(negedge clk);
    env_in = 1'b0;
    repeat (GAP) @(negedge clk);
    env_in = 1'b1;
    for (int i = 0; i < nlens; i++) begin
      repeat (lens[i]) @(negedge clk);
      env_in = 1'b0;
      repeat (GAP) @(negedge clk);
      env_in = 1'b1;
    end
    seen = 0;
    v_k  = -10;
    for (int k = 1; k <= POLL; k++) begin
      @(negedge clk);
      if (k == v_k + 1) begin
        check(frm_bits == 5'd0, "R9", "bits after valid", frm_bits, 0);
        check(frm_data == 31'd0, "R9", "data after valid", frm_data, 0);
      end
      if (frm_valid) begin
        seen++;
        v_k      = k;
        cap_data = frm_data;
        cap_bits = frm_bits;
      end
    end
  endtask

  task automatic expect_frame(input string req, input logic [30:0] ed, input int eb);
    check(seen == 1, req, "valid strobes", seen, 1);
    if (seen == 1) begin
      check(cap_bits == 5'(eb), req, "bit count", cap_bits, eb);
      check(cap_data == ed, req, "frame data", cap_data, ed);
    end
  endtask

  initial begin
    checks    = 0;
    failures  = 0;
    half_rate = 1'b0;
    env_in    = 1'b1;
    rst_n     = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(frm_valid == 1'b0 && frm_bits == 5'd0 && frm_data == 31'd0, "R1",
          "outputs in reset", {frm_valid, frm_bits}, 0);
    check(tmr_run == 1'b0, "R1", "timer in reset", tmr_run, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    check(frm_valid == 1'b0 && frm_bits == 5'd0 && tmr_run == 1'b0, "R1",
          "quiet after reset", {frm_valid, frm_bits, tmr_run}, 0);

    // Vector table: R2 R3 R5 R7 R8 R9
    for (int v = 0; v < NV; v++) begin
      logic [30:0] ed;
      int eb;
      nlens = V_BITS[v];
      ed    = '0;
      eb    = 0;
      for (int i = 0; i < V_BITS[v]; i++) begin
        lens[i] = V_PAT[v][i % 32] ? V_ONE[v] : V_ZERO[v];
        if (i < 31) begin
          ed[i] = V_PAT[v][i % 32];
          eb++;
        end
      end
      send_frame();
      if (V_BITS[v] <= 4) begin
        check(seen == 0, "R7", "runt frame strobes", seen, 0);
        check(frm_bits == 5'd0 && frm_data == 31'd0, "R7", "runt cleared",
              {frm_bits, frm_data}, 0);
      end else if (V_BITS[v] > 31) begin
        expect_frame("R8", ed, eb);
      end else if (v == 1) begin
        expect_frame("R2_R3_inner_edge", ed, eb);
      end else if (v == 2) begin
        expect_frame("R2_R3_outer_edge", ed, eb);
      end else begin
        expect_frame("R5", ed, eb);
      end
      // R6: strobe 142 clocks after the sampling edge, seen at the 143rd negedge
      if (v == 0) check(v_k == 143, "R6", "close latency", v_k, 143);
    end

    // R4: boundary and ignored intervals inside a frame
    nlens = 8;
    lens[0] = 120; lens[1] = 100; lens[2] = 60; lens[3] = 80;
    lens[4] = 120; lens[5] = 40;  lens[6] = 60; lens[7] = 120;
    send_frame();
    expect_frame("R4", 31'h15, 5);

    // R7 boundary: exactly 5 bits is kept
    nlens = 5;
    for (int i = 0; i < 5; i++) lens[i] = 60;
    send_frame();
    expect_frame("R7", 31'h0, 5);

    // R11: half-rate ticks, on-periods given in clocks
    half_rate = 1'b1;
    nlens = 5;
    lens[0] = 240; lens[1] = 120; lens[2] = 240; lens[3] = 240; lens[4] = 120;
    send_frame();
    expect_frame("R11", 31'h0D, 5);
    half_rate = 1'b0;
    repeat (4) @(negedge clk);

    // R10: idle stop and restart
    @(negedge clk);
    env_in = 1'b0;
    for (int k = 1; k <= 2402; k++) begin
      @(negedge clk);
      if (k == 3)    check(tmr_run == 1'b1, "R10", "run after edge", tmr_run, 1);
      if (k == 2401) check(tmr_run == 1'b1, "R10", "run before limit", tmr_run, 1);
      if (k == 2402) check(tmr_run == 1'b0, "R10", "stopped at limit", tmr_run, 0);
    end
    env_in = 1'b1;
    repeat (3) @(negedge clk);
    check(tmr_run == 1'b1, "R10", "restart on next edge", tmr_run, 1);
    check(frm_bits == 5'd0, "R4", "long interval adds no bit", frm_bits, 0);

    finish_run();
  end

endmodule